// File: doc/BRIEF.md
# Padded Vertex Count Calculator

This block turns an unsigned 32-bit vertex count into the padded count that a thread dispatcher works with. The padded count is always an odd factor (1, 3, 5, 7 or 9) times a power of two. Because of that form, a linear thread index can be split into a vertex index and an instance index with a small divider instead of a general one.

Small counts are rounded through a fixed step table. Larger counts are rounded by a rule that reads the leading one and the three bits just below it. The result is always strictly larger than the input and always a multiple of four.

The block registers its result once. Each output describes the count presented one clock earlier. Besides the padded count it reports the exponent `shift` and an odd-factor code `m`, so that padded = (2m+1)·2^shift.

Top module: `vtx_pad_calc`

## Requirements
- R1: While `rst_n` is low, `pad_o`, `odd_o` and `shift_o` are all zero.
- R2: Outputs change only on a rising clock edge, and they reflect the `cnt_i` value sampled at that edge (one cycle of latency).
- R3: Counts 0, 1, 2 and 3 give a padded count of 4, with `odd_o`=0 and `shift_o`=2.
- R4: Counts 4–7 give 8 (0,3). Counts 8–11 give 12 (1,2). Counts 12–15 give 16 (0,4). Counts 16–19 give 20 (2,2). Each pair is (`odd_o`,`shift_o`).
- R5: For counts of 20 and above, let n be the bit position of the leading one minus 3. When the leading four bits are 1000, the result is 9·2^n (`odd_o`=4, `shift_o`=n). Example: 70 gives 72, with code 4 and shift 3.
- R6: When the leading four bits are 1001, the result is 5·2^(n+1) (`odd_o`=2).
- R7: When the leading four bits are 101x, the result is 3·2^(n+2) (`odd_o`=1).
- R8: When the leading four bits are 110x, the result is 7·2^(n+1) (`odd_o`=3).
- R9: When the leading four bits are 111x, the result is 2^(n+4) (`odd_o`=0). An all-ones input therefore gives 2^32 on the 33-bit output.
- R10: `pad_o` always equals (2·`odd_o`+1)·2^`shift_o`.
- R11: `pad_o` is strictly greater than the count it was computed from, and its two low bits are zero.
- R12: `odd_o` never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 32 | Unsigned vertex count |
| pad_o | output | 33 | Padded count, registered |
| odd_o | output | 3 | Odd-factor code m, where the factor is 2m+1 |
| shift_o | output | 6 | Power-of-two exponent |

## Verification
The fixed step table and the leading-bit rule are both evaluated every cycle, and the result is chosen at the 19/20 boundary. The bench drives 19 and then 20 on consecutive cycles, and also walks every count from 0 to 4096 back to back. This lets a wrong hand-over show up as a result that is too small or wrongly encoded. Each result is judged against a model that looks for the smallest value of the allowed form (odd factor at most 9, exponent at least 2) that is strictly greater than the count.

// File: rtl/vtx_pad_calc.sv
module vtx_pad_calc #(
  parameter int CW = 32,
  parameter int SW = 6,
  parameter int SMALL_LIM = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  output logic [CW:0]   pad_o,
  output logic [2:0]    odd_o,
  output logic [SW-1:0] shift_o
);
  localparam int PW = CW + 1;

  logic [SW-1:0] lead;
  logic [SW-1:0] n_w;
  logic [3:0]    top;
  logic          big;
  logic [PW-1:0] pad_d;
  logic [2:0]    odd_d;
  logic [SW-1:0] shift_d;
  logic [4:0]    ratio;
  logic          live_q;

  always_comb begin
    lead = '0;
    for (int i = 0; i < CW; i++)
      if (cnt_i[i]) lead = SW'(i);
  end

  assign big = cnt_i >= CW'(SMALL_LIM);
  assign n_w = lead - SW'(3);
  assign top = 4'(cnt_i >> n_w);

  always_comb begin
    ratio   = 5'd16;
    odd_d   = 3'd0;
    shift_d = n_w + SW'(4);
    casez (top)
      4'b1000: begin ratio = 5'd9;  odd_d = 3'd4; shift_d = n_w;          end
      4'b1001: begin ratio = 5'd10; odd_d = 3'd2; shift_d = n_w + SW'(1); end
      4'b101?: begin ratio = 5'd12; odd_d = 3'd1; shift_d = n_w + SW'(2); end
      4'b110?: begin ratio = 5'd14; odd_d = 3'd3; shift_d = n_w + SW'(1); end
      default: ;
    endcase
    pad_d = PW'(ratio) << n_w;
    if (!big) begin
      pad_d = PW'({cnt_i[4:2] + 3'd1, 2'b00});
      case (cnt_i[4:2])
        3'd1:    begin odd_d = 3'd0; shift_d = SW'(3); end
        3'd2:    begin odd_d = 3'd1; shift_d = SW'(2); end
        3'd3:    begin odd_d = 3'd0; shift_d = SW'(4); end
        3'd4:    begin odd_d = 3'd2; shift_d = SW'(2); end
        default: begin odd_d = 3'd0; shift_d = SW'(2); end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_o   <= '0;
      odd_o   <= '0;
      shift_o <= '0;
      live_q  <= 1'b0;
    end else begin
      pad_o   <= pad_d;
      odd_o   <= odd_d;
      shift_o <= shift_d;
      live_q  <= 1'b1;
    end
  end

  AST_ABOVE_INPUT: assert property (@(posedge clk) disable iff (!rst_n) live_q |-> pad_o > {1'b0, $past(cnt_i)}); // R11
  AST_MULT_FOUR: assert property (@(posedge clk) disable iff (!rst_n) live_q |-> pad_o[1:0] == 2'b00); // R11
  AST_ENCODING: assert property (@(posedge clk) disable iff (!rst_n) live_q |-> pad_o == (PW'({odd_o, 1'b1}) << shift_o)); // R10
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) live_q |-> odd_o <= 3'd4); // R12
endmodule

// File: tb/sim_vtx_pad_calc.sv
module sim_vtx_pad_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cnt_i = '0;
  logic [32:0] pad_o;
  logic [2:0]  odd_o;
  logic [5:0]  shift_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vtx_pad_calc u0 (.clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .pad_o(pad_o), .odd_o(odd_o), .shift_o(shift_o));

  localparam int NV = 16;
  localparam logic [73:0] VEC [NV] = '{
    {32'd0,          33'd4,           3'd0, 6'd2},
    {32'd3,          33'd4,           3'd0, 6'd2},
    {32'd7,          33'd8,           3'd0, 6'd3},
    {32'd8,          33'd12,          3'd1, 6'd2},
    {32'd15,         33'd16,          3'd0, 6'd4},
    {32'd19,         33'd20,          3'd2, 6'd2},
    {32'd20,         33'd24,          3'd1, 6'd3},
    {32'd70,         33'd72,          3'd4, 6'd3},
    {32'd72,         33'd80,          3'd2, 6'd4},
    {32'd24,         33'd28,          3'd3, 6'd2},
    {32'h8000_0000,  33'h0_9000_0000, 3'd4, 6'd28},
    {32'h9000_0000,  33'h0_A000_0000, 3'd2, 6'd29},
    {32'hA000_0000,  33'h0_C000_0000, 3'd1, 6'd30},
    {32'hC800_0000,  33'h0_E000_0000, 3'd3, 6'd29},
    {32'hE000_0000,  33'h1_0000_0000, 3'd0, 6'd32},
    {32'hFFFF_FFFF,  33'h1_0000_0000, 3'd0, 6'd32}
  };
  localparam string VTAG [NV] = '{"R3", "R3", "R4", "R4", "R4", "R4", "R7", "R5",
                                  "R6", "R8", "R5", "R6", "R7", "R8", "R9", "R9"};

  function automatic void model(input logic [31:0] c, output logic [32:0] p,
                                output logic [2:0] m, output logic [5:0] s);
    logic [63:0] best;
    best = '1; p = '0; m = '0; s = '0;
    for (int mm = 0; mm < 5; mm++)
      for (int ss = 2; ss < 34; ss++) begin
        logic [63:0] v;
        v = 64'(2 * mm + 1) << ss;
        if (v > {32'd0, c} && v < best) begin
          best = v; p = best[32:0]; m = 3'(mm); s = 6'(ss);
        end
      end
  endfunction

  task automatic cmp(input string req, input logic [32:0] ep, input logic [2:0] em, input logic [5:0] es);
    n_chk++;
    if (pad_o !== ep || odd_o !== em || shift_o !== es) begin
      n_bad++;
      $display("FAIL %s cnt=%0d got pad=%0d m=%0d s=%0d exp pad=%0d m=%0d s=%0d",
               req, cnt_i, pad_o, odd_o, shift_o, ep, em, es);
    end
  endtask

  task automatic apply(input logic [31:0] c, input string req);
    logic [32:0] p; logic [2:0] m; logic [5:0] s;
    @(negedge clk) cnt_i = c;
    @(negedge clk);
    model(c, p, m, s);
    cmp(req, p, m, s);
    n_chk++;
    if (!(pad_o > {1'b0, c}) || pad_o[1:0] != 2'b00) begin
      n_bad++;
      $display("FAIL R11 cnt=%0d got pad=%0d exp >cnt and multiple of 4", c, pad_o);
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired got running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cnt_i = 32'd70;
    repeat (3) @(negedge clk);
    cmp("R1", 33'd0, 3'd0, 6'd0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk) cnt_i = VEC[k][73:42];
      @(negedge clk);
      cmp(VTAG[k], VEC[k][41:9], VEC[k][8:6], VEC[k][5:0]);
    end
    @(negedge clk) cnt_i = 32'd70;
    @(negedge clk) cnt_i = 32'd20;
    #1 cmp("R2", 33'd72, 3'd4, 6'd3);
    @(negedge clk) cmp("R2", 33'd24, 3'd1, 6'd3);
    @(negedge clk) cnt_i = 32'd19;
    @(negedge clk) cmp("R4", 33'd20, 3'd2, 6'd2);
    cnt_i = 32'd20;
    @(negedge clk) cmp("R7", 33'd24, 3'd1, 6'd3);
    for (int c = 0; c <= 4096; c++) apply(32'(c), "R10");
    for (int k = 0; k < 1500; k++) apply($urandom >> ($urandom % 32), "R12");
    @(negedge clk) rst_n = 1'b0;
    #1 cmp("R1", 33'd0, 3'd0, 6'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule